// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of an 8-bit successive approximation analog-to-digital converter. It presents a trial code to an external DAC, reads back one comparator bit that says whether the current trial bit should be kept, and settles one bit per clock, starting from the most significant bit. The DAC, the comparator, the reference and the oscillator are outside the block.

A conversion is requested with an active-low start strobe that may change at any time relative to the clock. The strobe passes through a two-stage synchronizer. While it stays low, the converter is held cleared, showing only the top bit of the trial code. Once it is released, bit decisions follow on consecutive falling clock edges. A `ready_o` flag goes high on the edge that settles the last bit. The result can be read through an active-low read enable that drives a tri-state data bus. When free-run mode is selected, the converter restarts by itself each time it finishes, so it yields one result every eight clock periods.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, with free-run off, `ready_o` is 1 and `trial_o` is 0.
- R2: Two rising edges after `start_n` goes low, the next falling edge clears the converter: `trial_o` becomes 0x80 and `ready_o` becomes 0. Both stay so, with no decisions made, for as long as `start_n` remains low.
- R3: After `start_n` returns high, no decision is taken until the synchronized start is seen high on a rising edge. The most significant bit is then decided on the next falling edge, and on that same edge bit 6 is set.
- R4: On each decision edge, the current trial bit keeps its value 1 when `cmp_keep` is 1 and is cleared when `cmp_keep` is 0. The next lower bit is set on the same edge. With a comparator that asserts keep when the trial code is at or below an input code, the final code equals that input code, for every code from 0 to 255.
- R5: `ready_o` rises on the eighth falling edge counted from the first decision edge, together with the least significant bit decision. It stays high and the code stays fixed while the converter is idle.
- R6: Driving `start_n` low during a conversion aborts it: `ready_o` does not rise for the aborted conversion, and the next result belongs to the new request.
- R7: While `rd_n` is 1, `data_o` is high impedance. While `rd_n` is 0, `data_o` equals the current trial register. Reading leaves the register unchanged.
- R8: With `free_run` at 1 and `start_n` held high, conversions begin without any start pulse and repeat every 8 clock periods. `ready_o` is high for the half period after each final decision edge and is low again by the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; decisions on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_n | input | 1 | Active-low conversion request, asynchronous to `clk` |
| free_run | input | 1 | 1 selects automatic back-to-back conversions |
| cmp_keep | input | 1 | Comparator result: 1 keeps the bit under trial |
| rd_n | input | 1 | Active-low read enable for the data bus |
| trial_o | output | 8 | Trial code driven to the external DAC |
| ready_o | output | 1 | High when a conversion has finished and data is valid |
| data_o | output | 8 | Tri-state result bus, driven only while `rd_n` is 0 |

## Verification
The main function is exercised by sweeping every one of the 256 input codes. This separates a wrong keep or clear decision at any bit position from a wrong order of bit settling. For each conversion the falling edges are counted from the synchronized release to the rise of `ready_o`, which tells an off-by-one in the sequencer apart from a decision taken before the settling edge. Aborts are started partway through a conversion with a different code, so that a stale result or a spurious `ready_o` pulse shows up as a mismatch. Free-run is measured by the spacing of successive results. Reads are checked with the bus both released and driven around a result that is not all ones.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Resolution of the converter in bits.
  localparam int unsigned SAR_BITS = 8;
  // Number of flops in each synchronizer chain.
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/sar_sync2.sv
module sar_sync2 #(
  parameter int unsigned STAGES  = sar_pkg::SYNC_STAGES,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int unsigned N_BITS = sar_pkg::SAR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_s,
  input  logic              free_run,
  input  logic              cmp_keep,
  output logic [N_BITS-1:0] trial,
  output logic [N_BITS-1:0] mask,
  output logic              ready,
  output logic              restart
);
  localparam logic [N_BITS-1:0] TOP_BIT = {1'b1, {(N_BITS-1){1'b0}}};
  localparam logic [N_BITS-1:0] LOW_BIT = {{(N_BITS-1){1'b0}}, 1'b1};

  logic [N_BITS-1:0] trial_q, trial_d;
  logic [N_BITS-1:0] mask_q, mask_d;
  logic [N_BITS-1:0] cur_trial, cur_mask;
  logic              done_q, done_d;
  logic              restart_q, restart_d;

  // Falling-edge decision path
  always_comb begin
    cur_trial = restart_q ? TOP_BIT : trial_q;
    cur_mask  = restart_q ? TOP_BIT : mask_q;
    trial_d   = cur_trial;
    mask_d    = cur_mask;
    done_d    = done_q;
    if (!start_s) begin
      trial_d = TOP_BIT;
      mask_d  = TOP_BIT;
      done_d  = 1'b0;
    end else if (cur_mask != '0) begin
      trial_d = (cur_trial & ~cur_mask)
              | (cmp_keep ? cur_mask : '0)
              | (cur_mask >> 1);
      mask_d  = cur_mask >> 1;
      done_d  = (cur_mask == LOW_BIT);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      mask_q  <= '0;
      done_q  <= 1'b1;
    end else begin
      trial_q <= trial_d;
      mask_q  <= mask_d;
      done_q  <= done_d;
    end
  end

  // Rising-edge free-run restart: loads the top bit half a period early
  always_comb begin
    restart_d = free_run & done_q & start_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart_q <= 1'b0;
    else        restart_q <= restart_d;
  end

  assign trial   = cur_trial;
  assign mask    = mask_q;
  assign ready   = done_q & ~restart_q;
  assign restart = restart_q;
endmodule

// File: rtl/sar_rdbuf.sv
module sar_rdbuf #(
  parameter int unsigned N_BITS = sar_pkg::SAR_BITS
) (
  input  logic              rd_n,
  input  logic [N_BITS-1:0] val,
  output wire  [N_BITS-1:0] bus
);
  for (genvar i = 0; i < N_BITS; i++) begin : g_bit
    assign bus[i] = rd_n ? 1'bz : val[i];
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int unsigned N_BITS = sar_pkg::SAR_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_n,
  input  logic              free_run,
  input  logic              cmp_keep,
  input  logic              rd_n,
  output logic [N_BITS-1:0] trial_o,
  output logic              ready_o,
  output wire  [N_BITS-1:0] data_o
);
  logic              rst_sync_n;
  logic              start_s;
  logic [N_BITS-1:0] seq_mask;
  logic              seq_restart;

  sar_sync2 #(.RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_sync_n)
  );

  sar_sync2 #(.RST_VAL(1'b1)) u_start_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     (start_n),
    .q     (start_s)
  );

  sar_seq #(.N_BITS(N_BITS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start_s  (start_s),
    .free_run (free_run),
    .cmp_keep (cmp_keep),
    .trial    (trial_o),
    .mask     (seq_mask),
    .ready    (ready_o),
    .restart  (seq_restart)
  );

  sar_rdbuf #(.N_BITS(N_BITS)) u_rdbuf (
    .rd_n (rd_n),
    .val  (trial_o),
    .bus  (data_o)
  );
endmodule

module sar_conv_ctrl_chk #(
  parameter int unsigned N_BITS = sar_pkg::SAR_BITS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_s,
  input logic              free_run,
  input logic              restart,
  input logic [N_BITS-1:0] mask,
  input logic [N_BITS-1:0] trial_o,
  input logic              ready_o
);
  localparam logic [N_BITS-1:0] TOP_BIT = {1'b1, {(N_BITS-1){1'b0}}};
  localparam logic [N_BITS-1:0] LOW_BIT = {{(N_BITS-1){1'b0}}, 1'b1};

  p_clear_hold_r2: assert property (@(negedge clk) disable iff (!rst_n)
    !start_s |=> (trial_o == TOP_BIT && !ready_o));

  p_mask_onehot_r4: assert property (@(negedge clk) disable iff (!rst_n)
    $onehot0(mask));

  p_step_down_r4: assert property (@(negedge clk) disable iff (!rst_n)
    (mask != '0 && start_s && !restart) |=> (mask == ($past(mask) >> 1) || mask == TOP_BIT));

  p_ready_after_lsb_r5: assert property (@(negedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(mask) == LOW_BIT);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && start_s && !free_run) |=> ($stable(trial_o) || !ready_o));

  p_free_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (free_run && ready_o) |=> !ready_o);
endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.N_BITS(N_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .start_s  (start_s),
  .free_run (free_run),
  .restart  (seq_restart),
  .mask     (seq_mask),
  .trial_o  (trial_o),
  .ready_o  (ready_o)
);

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_n = 1'b1;
  logic       free_run = 1'b0;
  logic       rd_n = 1'b1;
  logic [7:0] vin = 8'h00;
  logic       cmp_keep;
  logic [7:0] trial_o;
  logic       ready_o;
  wire  [7:0] data_bus;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  bit  mon_en = 1'b1;
  bit  counting = 1'b0;
  int  edge_cnt = 0;
  logic ready_prev = 1'b1;

  always #5 clk = ~clk;

  for (genvar i = 0; i < 8; i++) begin : g_pull
    pullup (data_bus[i]);
  end

  // Comparator model: keep the bit while the trial code is at or below the input
  assign cmp_keep = (trial_o <= vin);

  sar_conv_ctrl u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_n  (start_n),
    .free_run (free_run),
    .cmp_keep (cmp_keep),
    .rd_n     (rd_n),
    .trial_o  (trial_o),
    .ready_o  (ready_o),
    .data_o   (data_bus)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic at_drive();
    @(posedge clk); #2;
  endtask

  task automatic at_sample();
    @(negedge clk); #1;
  endtask

  // Monitor: pops the expected result whenever ready rises
  initial begin
    forever begin
      @(negedge clk); #1;
      if (counting) edge_cnt++;
      if (mon_en && ready_o && !ready_prev) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected ready", trial_o, 0);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(trial_o == e, "R4 final code", trial_o, e);
          check(edge_cnt == 8, "R5 falling edges to ready", edge_cnt, 8);
        end
        counting = 1'b0;
      end
      ready_prev = ready_o;
    end
  end

  // Drive start low, hold, release and push the expected code
  task automatic launch(input logic [7:0] code);
    vin = code;
    at_drive();
    start_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check(trial_o == 8'h80, "R2 cleared code", trial_o, 8'h80);
    check(ready_o == 1'b0, "R2 ready low", ready_o, 0);
    repeat (2) @(posedge clk);
    #2;
    check(trial_o == 8'h80, "R2 held while low", trial_o, 8'h80);
    start_n = 1'b1;
    exp_q.push_back(code);
    @(posedge clk);
    @(posedge clk); #1;
    check(trial_o == 8'h80, "R3 no decision before sync", trial_o, 8'h80);
    edge_cnt = 0;
    counting = 1'b1;
    @(negedge clk); #2;
    check(trial_o[7:6] == {code[7], 1'b1}, "R3 msb decision", trial_o[7:6], {code[7], 1'b1});
  endtask

  task automatic convert(input logic [7:0] code);
    launch(code);
    repeat (9) @(negedge clk);
    #2;
    check(exp_q.size() == 0, "R5 conversion finished", exp_q.size(), 0);
    check(ready_o == 1'b1, "R5 ready held", ready_o, 1);
  endtask

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    rd_n = 1'b0;
    at_sample();
    check(ready_o == 1'b1, "R1 ready after reset", ready_o, 1);
    check(trial_o == 8'h00, "R1 code after reset", trial_o, 0);
    check(data_bus == 8'h00, "R7 bus shows reset code", data_bus, 0);
    rd_n = 1'b1;

    // Full sweep of input codes
    for (int c = 0; c < 256; c++) convert(8'(c));

    // Read behaviour around a non-all-ones result
    convert(8'h5A);
    at_drive(); rd_n = 1'b1;
    at_sample();
    check(data_bus == 8'hFF, "R7 bus released", data_bus, 8'hFF);
    at_drive(); rd_n = 1'b0;
    at_sample();
    check(data_bus == 8'h5A, "R7 bus driven", data_bus, 8'h5A);
    repeat (5) at_sample();
    check(trial_o == 8'h5A, "R7 read non-destructive", trial_o, 8'h5A);
    check(data_bus == 8'h5A, "R7 bus still valid", data_bus, 8'h5A);
    rd_n = 1'b1;

    // Aborts in mid conversion
    launch(8'hC3);
    repeat (2) @(negedge clk);
    void'(exp_q.pop_back());
    counting = 1'b0;
    check(ready_o == 1'b0, "R6 busy before abort", ready_o, 0);
    convert(8'h24);
    launch(8'h01);
    repeat (3) @(negedge clk);
    void'(exp_q.pop_back());
    counting = 1'b0;
    convert(8'hFE);

    // Free-running mode
    mon_en = 1'b0;
    vin = 8'h3C;
    at_drive(); free_run = 1'b1;
    begin
      int hits = 0;
      int last = -1;
      bit first = 1'b1;
      for (int cyc = 0; cyc < 44; cyc++) begin
        at_sample();
        if (ready_o) begin
          if (first) begin
            first = 1'b0;
          end else begin
            check(trial_o == 8'h3C, "R8 free-run code", trial_o, 8'h3C);
            if (last >= 0) check(cyc - last == 8, "R8 free-run period", cyc - last, 8);
            last = cyc;
            hits++;
          end
        end
      end
      check(hits >= 4, "R8 free-run results", hits, 4);
    end
    at_drive(); free_run = 1'b0;
    repeat (12) at_sample();
    check(ready_o == 1'b1, "R8 idle after free-run", ready_o, 1);
    check(trial_o == 8'h3C, "R8 last free-run code", trial_o, 8'h3C);
    ready_prev = ready_o;
    mon_en = 1'b1;
    convert(8'h81);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule